// File: doc/BRIEF.md
# AES Encryption Round Sequencer

This block paces an iterative AES encryption datapath that computes one cipher round per iteration and shares one key-addition stage across every round. It sits idle until a plaintext block is flagged valid, the round-key schedule reports ready, and the mode input asks for encryption. It then walks the round index from 1 up to the round count that the key length sets. At each step it tells the multiplexer in front of the key addition which source to pass on. When the key-addition output holds the ciphertext, it raises a finished flag.

The substitution lookup in the datapath is registered, so each round takes two clocks. In the first clock the substitution result settles into its register. In the second clock the round state is updated through the key addition. The finished flag stays high until the producer withdraws its data-valid flag, and the block then returns to idle. If the key schedule drops its ready flag part way through a block, the sequencer gives up on that block and returns to idle without signalling completion.

Top module: `aes_enc_round_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, round_type is 2'b00, round_idx is 0 and finished is 0.
- R2: In idle, round_type is 2'b00 (initial round: raw input into key addition) and round_idx is 0. A block starts on a rising edge only when data_valid and key_ready are both sampled high and decrypt_sel is sampled low.
- R3: After a start, round_idx steps through 1, 2, ... up to the round count. Each value is held for exactly two clock cycles: the substitution-register cycle and the key-addition cycle.
- R4: While a round is running, round_type is 2'b01 (regular round: mix-column result) for indices below the round count and 2'b10 (final round: shift-row result, mix-column skipped) for the index equal to the round count. The code 2'b11 never appears.
- R5: The round count is 10, 12 or 14 for KEY_BITS of 128, 192 or 256. Any other key length is rejected at elaboration.
- R6: finished goes high in the cycle after the key-addition cycle of the final round. Counting the start edge as edge 1, this is after edge 2N+1. While finished is high, round_type is 2'b10 and round_idx equals the round count.
- R7: finished stays high for as long as data_valid is sampled high. After the first edge at which data_valid is sampled low, the block is idle (finished 0, round_type 2'b00, round_idx 0).
- R8: If key_ready is sampled low during either cycle of any round, the block is idle after that edge and finished is not raised for that block.
- R9: With decrypt_sel high, the block stays idle whatever data_valid and key_ready do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_valid | input | 1 | Plaintext block on the datapath input is valid |
| decrypt_sel | input | 1 | 1 selects decryption; this sequencer then stays idle |
| key_ready | input | 1 | Round-key schedule is complete |
| round_type | output | 2 | Key-addition source: 00 initial, 01 regular, 10 final |
| round_idx | output | IDX_W | Round-key index for the current step |
| finished | output | 1 | Key-addition output holds the ciphertext |

## Verification
A wrong phase or counter value shows up first on round_idx. A phase that is skipped or repeated shifts every later index change by one clock. That error grows into a finished flag that arrives early or late, and the 2N+1 edge count catches it within one block. A wrong comparison against the round count shows up at once as 2'b10 on a non-final index, or 2'b01 on the final one. A missed abort shows up as a finished flag in a block whose key schedule dropped. A missed hold in the done state shows up as finished falling while data_valid is still high.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SUB  = 2'd1,
      PH_ADD  = 2'd2,
      PH_DONE = 2'd3
   } seq_phase_e;

   typedef enum logic [1:0] {
      RT_INIT = 2'b00,
      RT_MID  = 2'b01,
      RT_LAST = 2'b10
   } round_type_e;

   // 128 -> 10, 192 -> 12, 256 -> 14
   function automatic int rounds_for_key(input int bits);
      return bits / 32 + 6;
   endfunction

   function automatic bit key_bits_legal(input int bits);
      return (bits == 128) || (bits == 192) || (bits == 256);
   endfunction

endpackage

// File: rtl/aes_seq_start_qual.sv
module aes_seq_start_qual (
   input  logic data_valid,
   input  logic key_ready,
   input  logic decrypt_sel,
   output logic start
);
   assign start = data_valid & key_ready & ~decrypt_sel;
endmodule

// File: rtl/aes_seq_round_ctr.sv
module aes_seq_round_ctr #(
   parameter int IDX_W      = 4,
   parameter int NUM_ROUNDS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] cnt,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ROUNDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   assign at_last = (cnt == LAST);
endmodule

// File: rtl/aes_seq_fsm.sv
module aes_seq_fsm
   import aes_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       key_ready,
   input  logic       data_valid,
   input  logic       at_last,
   output logic       ctr_clr,
   output logic       ctr_inc,
   output seq_phase_e phase
);
   seq_phase_e phase_nx;

   always_comb begin
      phase_nx = phase;
      ctr_clr  = 1'b0;
      ctr_inc  = 1'b0;
      unique case (phase)
         PH_IDLE: if (start) begin
            phase_nx = PH_SUB;
            ctr_inc  = 1'b1;
         end
         PH_SUB: begin
            if (!key_ready) begin
               phase_nx = PH_IDLE;
               ctr_clr  = 1'b1;
            end else begin
               phase_nx = PH_ADD;
            end
         end
         PH_ADD: begin
            if (!key_ready) begin
               phase_nx = PH_IDLE;
               ctr_clr  = 1'b1;
            end else if (at_last) begin
               phase_nx = PH_DONE;
            end else begin
               phase_nx = PH_SUB;
               ctr_inc  = 1'b1;
            end
         end
         PH_DONE: if (!data_valid) begin
            phase_nx = PH_IDLE;
            ctr_clr  = 1'b1;
         end
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= PH_IDLE;
      else
         phase <= phase_nx;
   end
endmodule

// File: rtl/aes_enc_round_seq.sv
module aes_enc_round_seq
   import aes_seq_pkg::*;
#(
   parameter int KEY_BITS = 128,
   parameter int IDX_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_valid,
   input  logic             decrypt_sel,
   input  logic             key_ready,
   output logic [1:0]       round_type,
   output logic [IDX_W-1:0] round_idx,
   output logic             finished
);
   localparam int NUM_ROUNDS = rounds_for_key(KEY_BITS);

   // R5
   if (!key_bits_legal(KEY_BITS)) begin : g_bad_key
      $error("aes_enc_round_seq: KEY_BITS must be 128, 192 or 256");
   end
   if (NUM_ROUNDS >= (1 << IDX_W)) begin : g_bad_idx
      $error("aes_enc_round_seq: IDX_W too narrow for round count");
   end

   logic             start;
   logic             ctr_clr;
   logic             ctr_inc;
   logic             at_last;
   logic [IDX_W-1:0] cnt;
   seq_phase_e       phase;
   round_type_e      rt;

   aes_seq_start_qual u_start (
      .data_valid  (data_valid),
      .key_ready   (key_ready),
      .decrypt_sel (decrypt_sel),
      .start       (start)
   );

   aes_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .key_ready  (key_ready),
      .data_valid (data_valid),
      .at_last    (at_last),
      .ctr_clr    (ctr_clr),
      .ctr_inc    (ctr_inc),
      .phase      (phase)
   );

   aes_seq_round_ctr #(
      .IDX_W      (IDX_W),
      .NUM_ROUNDS (NUM_ROUNDS)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctr_clr),
      .inc     (ctr_inc),
      .cnt     (cnt),
      .at_last (at_last)
   );

   always_comb begin
      unique case (phase)
         PH_IDLE:        rt = RT_INIT;
         PH_SUB, PH_ADD: rt = at_last ? RT_LAST : RT_MID;
         default:        rt = RT_LAST;
      endcase
   end

   assign round_type = rt;
   assign round_idx  = cnt;
   assign finished   = (phase == PH_DONE);
endmodule

// File: rtl/aes_enc_round_seq_chk.sv
module aes_enc_round_seq_chk
   import aes_seq_pkg::*;
#(
   parameter int KEY_BITS = 128,
   parameter int IDX_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             data_valid,
   input logic             decrypt_sel,
   input logic             key_ready,
   input logic [1:0]       round_type,
   input logic [IDX_W-1:0] round_idx,
   input logic             finished
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(rounds_for_key(KEY_BITS));

   logic go;
   logic idle;
   assign go   = data_valid & key_ready & ~decrypt_sel;
   assign idle = (round_idx == '0) && !finished;

   // R4
   no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_type != 2'b11);

   // R6
   fin_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finished |-> (round_type == 2'b10) && (round_idx == LAST));

   // R7
   fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (finished && data_valid) |=> finished);

   // R7
   fin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (finished && !data_valid) |=> (!finished && round_idx == '0));

   // R8
   fin_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(finished) |-> $past(key_ready));

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round_idx != '0 && !finished && !key_ready) |=> idle);

   // R2
   stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !go) |=> idle && round_type == 2'b00);

   // R3
   first_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && go) |=> (round_idx == 1) && (round_type == 2'b01));
endmodule

bind aes_enc_round_seq aes_enc_round_seq_chk #(
   .KEY_BITS (KEY_BITS),
   .IDX_W    (IDX_W)
) u_chk (.*);

// File: tb/aes_enc_round_seq_tb.sv
module aes_enc_round_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dv = 1'b0, kr = 1'b0, dec = 1'b0;

   logic [1:0] rt[3];
   logic [3:0] ri[3];
   logic       fin[3];

   int checks = 0;
   int errors = 0;
   bit over   = 1'b0;

   localparam int NR[3] = '{10, 12, 14};   // R5 per lane

   always #10 clk = ~clk;   // 50 MHz

   aes_enc_round_seq #(.KEY_BITS(128)) u_dut (
      .clk(clk), .rst_n(rst_n), .data_valid(dv), .decrypt_sel(dec), .key_ready(kr),
      .round_type(rt[0]), .round_idx(ri[0]), .finished(fin[0]));
   aes_enc_round_seq #(.KEY_BITS(192)) u_dut192 (
      .clk(clk), .rst_n(rst_n), .data_valid(dv), .decrypt_sel(dec), .key_ready(kr),
      .round_type(rt[1]), .round_idx(ri[1]), .finished(fin[1]));
   aes_enc_round_seq #(.KEY_BITS(256)) u_dut256 (
      .clk(clk), .rst_n(rst_n), .data_valid(dv), .decrypt_sel(dec), .key_ready(kr),
      .round_type(rt[2]), .round_idx(ri[2]), .finished(fin[2]));

   // Requirement-level model: phase 0 idle, 1 substitution, 2 key addition, 3 done
   int    mph[3];
   int    mcnt[3];
   string mtag[3];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < 3; l++) begin
            mph[l] = 0; mcnt[l] = 0; mtag[l] = "R1";
         end
      end else begin
         for (int l = 0; l < 3; l++) begin
            case (mph[l])
               0: if (dv && kr && !dec) begin
                     mph[l] = 1; mcnt[l] = 1; mtag[l] = "R3";
                  end else mtag[l] = dec ? "R9" : "R2";
               1: if (!kr) begin mph[l] = 0; mcnt[l] = 0; mtag[l] = "R8"; end
                  else mph[l] = 2;
               2: if (!kr) begin mph[l] = 0; mcnt[l] = 0; mtag[l] = "R8"; end
                  else if (mcnt[l] == NR[l]) begin mph[l] = 3; mtag[l] = "R6"; end
                  else begin mph[l] = 1; mcnt[l]++; mtag[l] = "R3"; end
               default: if (!dv) begin mph[l] = 0; mcnt[l] = 0; mtag[l] = "R7"; end
                        else mtag[l] = "R7";
            endcase
         end
      end
   end

   function automatic int exp_type(int ph, int cnt, int n);
      if (ph == 0) return 0;
      if (ph == 3) return 2;
      return (cnt == n) ? 2 : 1;
   endfunction

   task automatic check_all();
      for (int l = 0; l < 3; l++) begin
         int et, ei, ef;
         et = exp_type(mph[l], mcnt[l], NR[l]);
         ei = (mph[l] == 0) ? 0 : mcnt[l];
         ef = (mph[l] == 3) ? 1 : 0;
         checks++;
         if (int'(rt[l]) != et) begin
            errors++;
            $display("FAIL R4 (%s) lane %0d round_type act=%0d exp=%0d", mtag[l], l, rt[l], et);
         end
         checks++;
         if (int'(ri[l]) != ei) begin
            errors++;
            $display("FAIL %s lane %0d round_idx act=%0d exp=%0d", mtag[l], l, ri[l], ei);
         end
         checks++;
         if (int'(fin[l]) != ef) begin
            errors++;
            $display("FAIL R6 (%s) lane %0d finished act=%0d exp=%0d", mtag[l], l, fin[l], ef);
         end
      end
   endtask

   task automatic cyc(input logic d, input logic k, input logic x);
      @(negedge clk);
      check_all();
      dv = d; kr = k; dec = x;
   endtask

   initial begin
      #(20 * 200000);
      if (!over) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int first[3];
      void'($urandom(32'h5eed));
      // R1: outputs during reset
      repeat (3) begin
         @(negedge clk);
         for (int l = 0; l < 3; l++) begin
            checks++;
            if (rt[l] != 2'b00 || ri[l] != 4'd0 || fin[l] != 1'b0) begin
               errors++;
               $display("FAIL R1 lane %0d act=%0d/%0d/%0d exp=0/0/0", l, rt[l], ri[l], fin[l]);
            end
         end
      end
      rst_n = 1'b1;
      cyc(0, 1, 0);
      // R9: decrypt selected blocks the start
      repeat (6) cyc(1, 1, 1);
      // R2: key not ready blocks the start
      repeat (6) cyc(1, 0, 0);
      cyc(0, 0, 0);
      // R3 R4 R5 R6: full run; measure start-to-finished latency
      for (int l = 0; l < 3; l++) first[l] = 0;
      cyc(1, 1, 0);
      for (int i = 1; i <= 40; i++) begin
         cyc(1, 1, 0);
         for (int l = 0; l < 3; l++)
            if (fin[l] && first[l] == 0) first[l] = i;
      end
      for (int l = 0; l < 3; l++) begin
         checks++;
         if (first[l] != 2 * NR[l] + 1) begin
            errors++;
            $display("FAIL R5 lane %0d latency act=%0d exp=%0d", l, first[l], 2 * NR[l] + 1);
         end
      end
      // R7: release
      cyc(0, 1, 0);
      cyc(0, 1, 0);
      // R8: abort mid-run in both phases
      cyc(1, 1, 0);
      repeat (6) cyc(1, 1, 0);
      cyc(1, 0, 0);
      cyc(0, 1, 0);
      cyc(1, 1, 0);
      repeat (7) cyc(1, 1, 0);
      cyc(1, 0, 0);
      repeat (4) cyc(0, 1, 0);
      // random mix
      for (int i = 0; i < 4000; i++)
         cyc(($urandom % 100) < 90, ($urandom % 100) < 98, ($urandom % 100) < 10);
      cyc(0, 1, 0);
      over = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule